// File: doc/BRIEF.md
# Bit-Parallel Trinomial Field Multiplier

This block multiplies two elements of the binary extension field GF(2^M). Elements use a polynomial basis: bit i of a vector is the coefficient of x^i. The field is defined by the fixed trinomial x^M + x^K + 1, and both M and K are parameters, with defaults M = 233 and K = 74. The work is split into two combinational stages. The first stage is an AND/XOR array that forms the full unreduced product, a polynomial with 2M-1 coefficients. The second stage folds that product back to M bits. It uses fixed XOR equations, and the equation for each output bit depends on which index range the bit falls in.

A parameter can place registers around the two stages, which helps when the block has to meet timing on an FPGA. With the registers enabled, one operand pair can be accepted on every clock. Each result appears two cycles after its operands, together with a matching valid flag. The result register loads only when a valid operation reaches it, so the last result stays visible between operations. The parameters must satisfy 2K-1 < M so that the reduction index ranges do not overlap.

Top module: `gf_trinomial_mul`

## Requirements
- R1: `result` equals op_a times op_b modulo x^M + x^K + 1. Bit i of each vector is the coefficient of x^i.
- R2: If either operand is zero, the result is zero.
- R3: Multiplying by the element 1 (only bit 0 set) returns the other operand unchanged, whichever side the 1 is on.
- R4: x^(M-1) times x^(M-1) gives the reduced form of x^(2M-2). This is the product that exercises every reduction range at once.
- R5: All-ones operands, squared or multiplied by an arbitrary value, give the correctly reduced product.
- R6: With registers enabled (the default), `out_valid` rises exactly two clock cycles after the cycle in which `in_valid` was high. It is low in every other cycle.
- R7: A synchronous active-high `rst` clears `out_valid` and `result` to zero.
- R8: While no valid operation completes, `result` holds its previous value. Operands presented with `in_valid` low are ignored.
- R9: Operations issued in consecutive cycles each produce their own correct result, one per cycle, in issue order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands on op_a/op_b are to be multiplied |
| op_a | input | M | First operand, bit i is the coefficient of x^i |
| op_b | input | M | Second operand, bit i is the coefficient of x^i |
| out_valid | output | 1 | `result` holds a newly finished product |
| result | output | M | Reduced product |

## Verification
Two things can happen in the same cycle: new operands are captured at the input register while an earlier product leaves the output register. Back-to-back streams of random operands provoke this, and they are broken up by idle cycles in which junk operands are driven with `in_valid` low. A behavioural model in the bench, built on the MSB-first shift-and-reduce method, keeps a queue of expected results stamped with their due cycle. On every cycle the bench checks the valid flag and the result value against that queue. On idle cycles it also checks that the previous result is still held.

// File: rtl/gf_trimul_pkg.sv
package gf_trimul_pkg;

    // Reduction equation groups, selected by output bit index.
    typedef enum logic [2:0] {
        GRP_LOW   = 3'd0,  // i <  K-1 : s_i, s_(M+i), s_(2M-K+i)
        GRP_KNEE  = 3'd1,  // i == K-1 : s_i, s_(M+i)
        GRP_MID   = 3'd2,  // K <= i <= 2K-2 : four terms
        GRP_UPPER = 3'd3,  // 2K-1 <= i <= M-2 : s_i, s_(M+i), s_(M-K+i)
        GRP_TOP   = 3'd4   // i == M-1 : s_(M-1), s_(2M-K-1)
    } red_grp_e;

    function automatic int prod_width(input int m);
        return 2 * m - 1;
    endfunction

    function automatic red_grp_e grp_of(input int i, input int m, input int k);
        if (i == m - 1)          return GRP_TOP;
        else if (i < k - 1)      return GRP_LOW;
        else if (i == k - 1)     return GRP_KNEE;
        else if (i <= 2 * k - 2) return GRP_MID;
        else                     return GRP_UPPER;
    endfunction

    // Lowest and highest operand-A index feeding product coefficient n.
    function automatic int conv_lo(input int n, input int m);
        return (n > m - 1) ? (n - m + 1) : 0;
    endfunction

    function automatic int conv_hi(input int n, input int m);
        return (n < m - 1) ? n : (m - 1);
    endfunction

endpackage

// File: rtl/gf_prod_array.sv
module gf_prod_array
    import gf_trimul_pkg::*;
#(
    parameter int M = 233
) (
    input  logic [M-1:0]             mul_x,
    input  logic [M-1:0]             mul_y,
    output logic [prod_width(M)-1:0] prod
);

    localparam int PW = prod_width(M);

    // One coefficient per output degree: XOR of all x_i & y_(n-i).
    for (genvar n = 0; n < PW; n++) begin : g_coef
        localparam int LO = conv_lo(n, M);
        localparam int HI = conv_hi(n, M);
        logic acc;
        always_comb begin
            acc = 1'b0;
            for (int i = LO; i <= HI; i++) begin
                acc = acc ^ (mul_x[i] & mul_y[n-i]);
            end
        end
        assign prod[n] = acc;
    end

endmodule

// File: rtl/gf_tri_reduce.sv
module gf_tri_reduce
    import gf_trimul_pkg::*;
#(
    parameter int M = 233,
    parameter int K = 74
) (
    input  logic [prod_width(M)-1:0] prod,
    output logic [M-1:0]             red
);

    // x^(M+j) = x^(K+j) + x^j, applied twice where the first fold
    // lands at or above degree M; out-of-range terms are absent.
    for (genvar i = 0; i < M; i++) begin : g_bit
        localparam red_grp_e G = grp_of(i, M, K);
        if (G == GRP_LOW) begin : g_low
            assign red[i] = prod[i] ^ prod[M+i] ^ prod[2*M-K+i];
        end else if (G == GRP_KNEE) begin : g_knee
            assign red[i] = prod[i] ^ prod[M+i];
        end else if (G == GRP_MID) begin : g_mid
            assign red[i] = prod[i] ^ prod[M+i] ^ prod[M-K+i] ^ prod[2*M-2*K+i];
        end else if (G == GRP_UPPER) begin : g_upper
            assign red[i] = prod[i] ^ prod[M+i] ^ prod[M-K+i];
        end else begin : g_top
            assign red[i] = prod[M-1] ^ prod[2*M-K-1];
        end
    end

endmodule

// File: rtl/gf_io_stage.sv
module gf_io_stage #(
    parameter int W      = 8,
    parameter bit REG_EN = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_v,
    input  logic [W-1:0] in_d,
    output logic         out_v,
    output logic [W-1:0] out_d
);

    if (REG_EN) begin : g_reg
        logic         v_q;
        logic [W-1:0] d_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                v_q <= 1'b0;
                d_q <= '0;
            end else begin
                v_q <= in_v;
                if (in_v) d_q <= in_d;
            end
        end
        assign out_v = v_q;
        assign out_d = d_q;
    end else begin : g_pass
        assign out_v = in_v;
        assign out_d = in_d;
    end

endmodule

// File: rtl/gf_trinomial_mul.sv
module gf_trinomial_mul
    import gf_trimul_pkg::*;
#(
    parameter int M      = 233,
    parameter int K      = 74,
    parameter bit REG_EN = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [M-1:0] op_a,
    input  logic [M-1:0] op_b,
    output logic         out_valid,
    output logic [M-1:0] result
);

    localparam int PW = prod_width(M);
    localparam int OW = 2 * M;

    typedef struct packed {
        logic [M-1:0] a;
        logic [M-1:0] b;
    } opnd_t;

    opnd_t          opnd_in;
    opnd_t          opnd_q;
    logic [OW-1:0]  opnd_bus;
    logic           mid_v;
    logic [PW-1:0]  prod_w;
    logic [M-1:0]   red_w;

    assign opnd_in = '{a: op_a, b: op_b};

    gf_io_stage #(.W(OW), .REG_EN(REG_EN)) u_in_stage (
        .clk   (clk),
        .rst   (rst),
        .in_v  (in_valid),
        .in_d  (opnd_in),
        .out_v (mid_v),
        .out_d (opnd_bus)
    );

    assign opnd_q = opnd_bus;

    gf_prod_array #(.M(M)) u_prod (
        .mul_x (opnd_q.a),
        .mul_y (opnd_q.b),
        .prod  (prod_w)
    );

    gf_tri_reduce #(.M(M), .K(K)) u_reduce (
        .prod (prod_w),
        .red  (red_w)
    );

    gf_io_stage #(.W(M), .REG_EN(REG_EN)) u_out_stage (
        .clk   (clk),
        .rst   (rst),
        .in_v  (mid_v),
        .in_d  (red_w),
        .out_v (out_valid),
        .out_d (result)
    );

    // R1: a product with no degree >= M passes reduction untouched.
    a_r1_low_degree_passthru: assert property (@(posedge clk) disable iff (rst)
        (prod_w[PW-1:M] == '0) |-> (red_w == prod_w[M-1:0]));

    // R2: zero operand yields zero after both stages.
    a_r2_zero_operand: assert property (@(posedge clk) disable iff (rst)
        ((opnd_q.a == '0) || (opnd_q.b == '0)) |-> (red_w == '0));

    // R3: multiplying by one returns the other operand.
    a_r3_identity: assert property (@(posedge clk) disable iff (rst)
        (opnd_q.b == M'(1)) |-> (red_w == opnd_q.a));

    if (REG_EN) begin : g_chk
        logic [1:0] age_q;
        always_ff @(posedge clk) begin
            if (rst)                age_q <= 2'd0;
            else if (age_q != 2'd2) age_q <= age_q + 2'd1;
        end

        // R6: valid appears exactly two cycles after issue.
        a_r6_valid_latency: assert property (@(posedge clk) disable iff (rst)
            (age_q == 2'd2) |-> (out_valid == $past(in_valid, 2)));

        // R8: result only moves when a valid operation reaches it.
        a_r8_result_hold: assert property (@(posedge clk) disable iff (rst)
            ((age_q != 2'd0) && !$past(mid_v)) |-> $stable(result));
    end

endmodule

// File: tb/gf_trinomial_mul_tb_top.sv
module gf_trinomial_mul_tb_top;

    localparam int M = 233;
    localparam int K = 74;

    typedef struct {
        int           due;
        logic [M-1:0] val;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [M-1:0] op_a = '0;
    logic [M-1:0] op_b = '0;
    logic         out_valid;
    logic [M-1:0] result;

    int           cyc = 0;
    int           checks = 0;
    int           errors = 0;
    exp_t         q[$];
    logic [M-1:0] last_res = '0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    gf_trinomial_mul #(.M(M), .K(K), .REG_EN(1'b1)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .op_a      (op_a),
        .op_b      (op_b),
        .out_valid (out_valid),
        .result    (result)
    );

    // MSB-first shift-and-reduce model.
    function automatic logic [M-1:0] ref_mul(input logic [M-1:0] x, input logic [M-1:0] y);
        logic [M:0] acc;
        logic [M:0] poly;
        acc  = '0;
        poly = '0;
        poly[M] = 1'b1;
        poly[K] = 1'b1;
        poly[0] = 1'b1;
        for (int i = M - 1; i >= 0; i--) begin
            acc = {acc[M-1:0], 1'b0};
            if (acc[M]) acc = acc ^ poly;
            if (y[i]) acc[M-1:0] = acc[M-1:0] ^ x;
        end
        return acc[M-1:0];
    endfunction

    function automatic logic [M-1:0] rnd_elem();
        logic [M-1:0] v;
        v = '0;
        for (int i = 0; i < M; i += 32) begin
            v = (v << 32) ^ M'($urandom);
        end
        return v;
    endfunction

    task automatic check_outputs();
        if (q.size() > 0 && q[0].due == cyc) begin
            checks++;
            if (out_valid !== 1'b1 || result !== q[0].val) begin
                errors++;
                $display("FAIL %s: valid=%b result=%h expected valid=1 result=%h",
                         q[0].tag, out_valid, result, q[0].val);
            end
            last_res = q[0].val;
            void'(q.pop_front());
        end else begin
            checks++;
            if (out_valid !== 1'b0) begin
                errors++;
                $display("FAIL R6: out_valid=%b expected 0 at cycle %0d", out_valid, cyc);
            end
            checks++;
            if (result !== last_res) begin
                errors++;
                $display("FAIL R8: result=%h expected held %h", result, last_res);
            end
        end
    endtask

    task automatic issue(input logic [M-1:0] x, input logic [M-1:0] y,
                         input logic v, input string tag);
        @(negedge clk);
        check_outputs();
        in_valid = v;
        op_a     = x;
        op_b     = y;
        if (v) q.push_back('{due: cyc + 2, val: ref_mul(x, y), tag: tag});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) issue(rnd_elem(), rnd_elem(), 1'b0, "R8");
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        logic [M-1:0] one_e;
        logic [M-1:0] top_e;
        logic [M-1:0] ones_e;
        one_e  = M'(1);
        top_e  = '0;
        top_e[M-1] = 1'b1;
        ones_e = '1;

        // R7: reset with valid operands applied must leave outputs clear.
        in_valid = 1'b1;
        op_a = rnd_elem();
        op_b = rnd_elem();
        repeat (4) @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || result !== '0) begin
            errors++;
            $display("FAIL R7: valid=%b result=%h expected 0/0", out_valid, result);
        end

        // R2 zero operands, R3 identity on either side.
        issue('0, rnd_elem(), 1'b1, "R2");
        issue(rnd_elem(), '0, 1'b1, "R2");
        issue(rnd_elem(), one_e, 1'b1, "R3");
        issue(one_e, rnd_elem(), 1'b1, "R3");
        idle(3);
        // R4 highest-degree square, R5 all-ones.
        issue(top_e, top_e, 1'b1, "R4");
        issue(ones_e, ones_e, 1'b1, "R5");
        issue(ones_e, rnd_elem(), 1'b1, "R5");
        idle(4);

        // R9 back-to-back stream, R1 random values.
        for (int i = 0; i < 150; i++) issue(rnd_elem(), rnd_elem(), 1'b1, "R9");
        idle(3);

        // R1 / R8 mixed issue and idle cycles.
        for (int i = 0; i < 200; i++) begin
            if ($urandom_range(0, 2) != 0) issue(rnd_elem(), rnd_elem(), 1'b1, "R1");
            else                           issue(rnd_elem(), rnd_elem(), 1'b0, "R8");
        end
        idle(4);

        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R6: %0d results never appeared, expected 0", q.size());
        end
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R9: watchdog expired at cycle %0d, expected completion", cyc);
        finish_run();
    end

endmodule